// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line Refill

This block is a small read-only instruction cache addressed in words. A fetch presents a word address; the block cuts it into a word offset in the low bits, a line index above that, and a tag in the remaining upper bits. It then checks the selected line's valid flag and stored tag. A hit returns the word in the same cycle. A miss claims the line and starts a refill sequencer. The sequencer reads the whole line, word by word, from a backing memory whose latency it models itself. The requested word is delivered on the last refill cycle.

Two refill timings are offered. In the non-burst timing every word costs the full memory latency. In the burst timing only the first word pays it and each later word takes one cycle. The `burst_en` input selects the timing and is sampled when the miss is detected. Two saturating counters record hits and misses.

The controller has two states, LOOKUP and FILL. LOOKUP→FILL is taken on a miss. FILL→LOOKUP is taken on the final beat. LOOKUP stays in LOOKUP on a hit or when no request is present. The refill sequencer has three states: IDLE, LEAD (waiting for the first word) and TAIL (later words). Its transitions are IDLE→LEAD on a miss, LEAD→TAIL after the first word, TAIL→TAIL between later words, and LEAD or TAIL→IDLE after the last word.

Top module: `icache_core`

## Requirements
- R1: The word address is split with the word offset in bits [1:0], the line index in bits [3:2] and the tag in bits [15:4]. Word address a therefore uses line (a/4) mod 4, so words 0–3 and 16–19 compete for line 0.
- R2: After reset every line is invalid, both counters read zero, `mem_rd` is low, and `req_ready` is low while `req_valid` is low.
- R3: A request that hits raises `req_ready` in the same cycle, and `rsp_data` carries the memory word for that address.
- R4: A miss spends one cycle with `req_ready` low. The refill then reads offsets 0,1,2,3 of the line in that order on `mem_addr`, with `mem_rd` high throughout. `req_ready` stays low until the last refill cycle, which delivers the requested word.
- R5: With `burst_en` low at the miss, each word takes 5 cycles, so a miss costs 21 cycles from request to ready.
- R6: With `burst_en` high at the miss, the first word takes 5 cycles and each later word takes 1 cycle, so a miss costs 9 cycles.
- R7: A miss to a valid line replaces the old block. A later fetch of the old block misses.
- R8: `hit_count` and `miss_count` each rise by one after every hit or miss respectively, and both hold at all-ones instead of wrapping.
- R9: Fetching words 0..10 and then three passes over 11..30 yields 55 hits and 16 misses. The fetch takes 391 cycles with non-burst timing and 199 cycles with burst timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_en | input | 1 | Selects burst refill timing, sampled on a miss |
| req_valid | input | 1 | Fetch request, held with its address until ready |
| req_addr | input | ADDR_W | Word address of the fetch |
| req_ready | output | 1 | Fetch completes this cycle |
| rsp_data | output | DATA_W | Fetched word, valid with req_ready |
| mem_rd | output | 1 | Refill in progress |
| mem_addr | output | ADDR_W | Word address being read from memory |
| mem_rdata | input | DATA_W | Memory word for mem_addr |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
On the final refill cycle the data array writes the last word of the line, and the requested word is handed to the requester in that same cycle. When the requested word is that last word, it must come straight from the memory port rather than from the array. The bench provokes this by fetching a word at offset 3 of an empty line. On every clock, a behavioural model compares `rsp_data` and the cycle in which `req_ready` rises. The same model checks the beat address and the counter updates, which fall in the cycle a hit is served.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [0:0] {
        S_LOOKUP,
        S_FILL
    } ctrl_state_t;

    typedef enum logic [1:0] {
        RF_IDLE,
        RF_LEAD,
        RF_TAIL
    } refill_state_t;

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
    parameter int LINES = 4,
    parameter int TAG_W = 12,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             claim,
    input  logic [IDX_W-1:0] claim_idx,
    input  logic [TAG_W-1:0] claim_tag,
    input  logic             commit,
    input  logic [IDX_W-1:0] commit_idx
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (claim && claim_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= claim_tag;
            end else if (commit && commit_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end

endmodule

// File: rtl/icache_data.sv
module icache_data #(
    parameter int LINES  = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(LINES),
    parameter int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);

    localparam int ENTRIES = LINES * WORDS;

    logic [DATA_W-1:0] store_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    assign rd_data = store_q[{rd_idx, rd_off}];

endmodule

// File: rtl/icache_refill.sv
module icache_refill
    import icache_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORDS     = 4,
    parameter int FIRST_LAT = 5,
    parameter int BURST_LAT = 1,
    parameter int OFF_W     = $clog2(WORDS),
    parameter int LINE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              burst,
    input  logic [LINE_W-1:0] line_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat_done,
    output logic [OFF_W-1:0]  beat_off,
    output logic              last_beat
);

    localparam int MAX_LAT = (FIRST_LAT > BURST_LAT) ? FIRST_LAT : BURST_LAT;
    localparam int LAT_W   = $clog2(MAX_LAT) + 1;
    localparam logic [LAT_W-1:0] FIRST_RELOAD = LAT_W'(FIRST_LAT - 1);
    localparam logic [LAT_W-1:0] BURST_RELOAD = LAT_W'(BURST_LAT - 1);
    localparam logic [OFF_W-1:0] LAST_OFF     = OFF_W'(WORDS - 1);

    refill_state_t     state_q, state_d;
    logic [OFF_W-1:0]  beat_q, beat_d;
    logic [LAT_W-1:0]  wait_q, wait_d;
    logic              burst_q;
    logic [LINE_W-1:0] line_q;
    logic              word_arrives;
    logic [LAT_W-1:0]  reload;

    assign word_arrives = (state_q != RF_IDLE) && (wait_q == '0);
    assign reload       = burst_q ? BURST_RELOAD : FIRST_RELOAD;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        wait_d  = wait_q;
        unique case (state_q)
            RF_IDLE: begin
                if (start) begin
                    state_d = RF_LEAD;
                    beat_d  = '0;
                    wait_d  = FIRST_RELOAD;
                end
            end
            RF_LEAD, RF_TAIL: begin
                if (word_arrives) begin
                    if (beat_q == LAST_OFF) begin
                        state_d = RF_IDLE;
                    end else begin
                        state_d = RF_TAIL;
                        beat_d  = beat_q + OFF_W'(1);
                        wait_d  = reload;
                    end
                end else begin
                    wait_d = wait_q - LAT_W'(1);
                end
            end
            default: state_d = RF_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RF_IDLE;
            beat_q  <= '0;
            wait_q  <= '0;
            burst_q <= 1'b0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            wait_q  <= wait_d;
            if (state_q == RF_IDLE && start) begin
                burst_q <= burst;
                line_q  <= line_addr;
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd    = (state_q != RF_IDLE);
        mem_addr  = {line_q, beat_q};
        beat_done = word_arrives;
        beat_off  = beat_q;
        last_beat = word_arrives && (beat_q == LAST_OFF);
    end

endmodule

// File: rtl/icache_stats.sv
module icache_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_inc,
    input  logic             miss_inc,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);

    logic [1:0]       inc;
    logic [CNT_W-1:0] cnt_q [2];

    assign inc = {miss_inc, hit_inc};

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (inc[g] && cnt_q[g] != '1) begin
                cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end
        end
    end

    assign hit_count  = cnt_q[0];
    assign miss_count = cnt_q[1];

endmodule

// File: rtl/icache_core.sv
module icache_core
    import icache_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int LINES     = 4,
    parameter int WORDS     = 4,
    parameter int FIRST_LAT = 5,
    parameter int BURST_LAT = 1,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    ctrl_state_t       state_q, state_d;

    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              tag_valid;
    logic [TAG_W-1:0]  tag_stored;
    logic              lookup_hit;
    logic              miss_start;
    logic [DATA_W-1:0] arr_data;
    logic              beat_done;
    logic [OFF_W-1:0]  beat_off;
    logic              last_beat;
    logic              fill_done;

    assign req_off = req_addr[OFF_W-1:0];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    assign lookup_hit = (state_q == S_LOOKUP) && req_valid &&
                        tag_valid && (tag_stored == req_tag);
    assign miss_start = (state_q == S_LOOKUP) && req_valid &&
                        !(tag_valid && (tag_stored == req_tag));
    assign fill_done  = (state_q == S_FILL) && last_beat;

    icache_tags #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (req_idx),
        .rd_valid   (tag_valid),
        .rd_tag     (tag_stored),
        .claim      (miss_start),
        .claim_idx  (req_idx),
        .claim_tag  (req_tag),
        .commit     (fill_done),
        .commit_idx (mem_addr[OFF_W +: IDX_W])
    );

    icache_data #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (beat_done),
        .wr_idx  (mem_addr[OFF_W +: IDX_W]),
        .wr_off  (beat_off),
        .wr_data (mem_rdata),
        .rd_idx  (req_idx),
        .rd_off  (req_off),
        .rd_data (arr_data)
    );

    icache_refill #(
        .ADDR_W    (ADDR_W),
        .WORDS     (WORDS),
        .FIRST_LAT (FIRST_LAT),
        .BURST_LAT (BURST_LAT),
        .OFF_W     (OFF_W),
        .LINE_W    (LINE_W)
    ) u_refill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (miss_start),
        .burst     (burst_en),
        .line_addr (req_addr[ADDR_W-1:OFF_W]),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .beat_done (beat_done),
        .beat_off  (beat_off),
        .last_beat (last_beat)
    );

    icache_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_inc    (lookup_hit),
        .miss_inc   (miss_start),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // controller next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LOOKUP: if (miss_start) state_d = S_FILL;
            S_FILL:   if (last_beat)  state_d = S_LOOKUP;
            default:  state_d = S_LOOKUP;
        endcase
    end

    // controller state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

    // controller outputs; the final word is forwarded from memory
    always_comb begin
        req_ready = lookup_hit || fill_done;
        rsp_data  = arr_data;
        if (fill_done && (req_off == beat_off)) begin
            rsp_data = mem_rdata;
        end
    end

endmodule

// File: rtl/icache_checker.sv
module icache_checker #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);

    // R2: completion is only signalled for a present request
    a_r2_ready_needs_valid: assert property (
        @(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid
    );

    // R4: a refill ends in the cycle that delivers the word
    a_r4_refill_ends_ready: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> $past(req_ready)
    );

    // R4: all beats of one refill stay within one line
    a_r4_line_stable: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |->
            (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))
    );

    // R8: counters never decrease
    a_r8_no_wrap: assert property (
        @(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hit_count >= $past(hit_count)) &&
                         (miss_count >= $past(miss_count))
    );

    // R8: a hit and a miss never count in the same cycle
    a_r8_one_step: assert property (
        @(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones({hit_count != $past(hit_count),
                                     miss_count != $past(miss_count)}) <= 1
    );

endmodule

bind icache_core icache_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/test_icache_core.sv
module test_icache_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic [31:0] rsp_data;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata;
    logic [31:0] hit_count;
    logic [31:0] miss_count;

    logic        s_ready;
    logic [31:0] s_data;
    logic        s_mem_rd;
    logic [15:0] s_mem_addr;
    logic [31:0] s_mem_rdata;
    logic [2:0]  s_hits;
    logic [2:0]  s_misses;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] word_of(input logic [15:0] a);
        return {a, ~a};
    endfunction

    assign mem_rdata   = word_of(mem_addr);
    assign s_mem_rdata = word_of(s_mem_addr);

    icache_core i_icache_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_en   (burst_en),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rsp_data   (rsp_data),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    icache_core #(.CNT_W(3)) i_sat (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_en   (burst_en),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (s_ready),
        .rsp_data   (s_data),
        .mem_rd     (s_mem_rd),
        .mem_addr   (s_mem_addr),
        .mem_rdata  (s_mem_rdata),
        .hit_count  (s_hits),
        .miss_count (s_misses)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, compared every clock
    bit   m_valid [4];
    int   m_tag   [4];
    int   m_hits, m_misses, m_remain, m_len;
    bit   m_burst;

    always @(negedge clk) begin
        if (!rst_n) begin
            foreach (m_valid[i]) begin
                m_valid[i] = 1'b0;
                m_tag[i]   = 0;
            end
            m_hits = 0; m_misses = 0; m_remain = 0; m_len = 0; m_burst = 1'b0;
        end else begin
            int a, line, k, beat;
            a    = int'(req_addr);
            line = (a / 4) % 4;
            chk("R8 hit count", 64'(hit_count), 64'(m_hits));
            chk("R8 miss count", 64'(miss_count), 64'(m_misses));
            chk("R4 mem_rd", 64'(mem_rd), 64'(m_remain > 0));
            if (m_remain == 0) begin
                if (!req_valid) begin
                    chk("R2 idle ready", 64'(req_ready), 64'd0);
                end else if (m_valid[line] && m_tag[line] == a / 16) begin
                    chk("R3 hit ready", 64'(req_ready), 64'd1);
                    chk("R3 hit data", 64'(rsp_data), 64'(word_of(req_addr)));
                    m_hits++;
                end else begin
                    chk("R4 miss cycle ready", 64'(req_ready), 64'd0);
                    m_misses++;
                    m_burst = burst_en;
                    m_len   = burst_en ? 8 : 20;
                    m_remain = m_len;
                    m_valid[line] = 1'b0;
                    m_tag[line]   = a / 16;
                end
            end else begin
                k    = m_len - m_remain;
                beat = m_burst ? ((k < 5) ? 0 : k - 4) : k / 5;
                chk(m_burst ? "R6 beat addr" : "R5 beat addr",
                    64'(mem_addr), 64'(((a / 4) * 4) + beat));
                chk("R4 fill ready", 64'(req_ready), 64'(m_remain == 1));
                if (m_remain == 1) begin
                    chk("R4 fill data", 64'(rsp_data), 64'(word_of(req_addr)));
                    m_valid[line] = 1'b1;
                end
                m_remain--;
            end
        end
    end

    task automatic fetch(input int a, output int cyc);
        bit got;
        req_addr  = 16'(a);
        req_valid = 1'b1;
        cyc = 0;
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            cyc++;
            got = req_ready;
            @(posedge clk);
            #1;
        end
        req_valid = 1'b0;
    endtask

    task automatic fetch_exp(input int a, input int exp, input string req);
        int c;
        fetch(a, c);
        chk(req, 64'(c), 64'(exp));
    endtask

    task automatic do_reset(input bit burst);
        rst_n = 1'b0;
        req_valid = 1'b0;
        burst_en = burst;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset ready", 64'(req_ready), 64'd0);
        chk("R2 reset mem_rd", 64'(mem_rd), 64'd0);
        chk("R2 reset hits", 64'(hit_count), 64'd0);
        chk("R2 reset misses", 64'(miss_count), 64'd0);
        @(posedge clk);
        #1;
    endtask

    task automatic run_trace(input bit burst, input int exp_cycles);
        int sum, c;
        do_reset(burst);
        sum = 0;
        for (int a = 0; a <= 10; a++) begin
            fetch(a, c);
            sum += c;
        end
        for (int it = 0; it < 3; it++) begin
            for (int a = 11; a <= 30; a++) begin
                fetch(a, c);
                sum += c;
            end
        end
        @(negedge clk);
        chk("R9 hits", 64'(hit_count), 64'd55);
        chk("R9 misses", 64'(miss_count), 64'd16);
        chk("R9 cycles", 64'(sum), 64'(exp_cycles));
        chk("R8 saturated hits", 64'(s_hits), 64'd7);
        chk("R8 saturated misses", 64'(s_misses), 64'd7);
        @(posedge clk);
        #1;
    endtask

    initial begin
        run_trace(1'b0, 391);
        run_trace(1'b1, 199);

        do_reset(1'b0);
        fetch_exp(3, 21, "R5 forwarded last word");
        fetch_exp(0, 1, "R3 hit offset 0");
        fetch_exp(2, 1, "R1 same line hit");
        repeat (3) @(posedge clk);
        #1;
        fetch_exp(19, 21, "R7 alias of line 0");
        fetch_exp(16, 1, "R1 new block hit");
        fetch_exp(3, 21, "R7 old block evicted");
        burst_en = 1'b1;
        fetch_exp(13, 9, "R6 burst miss");
        fetch_exp(12, 1, "R6 burst line hit");
        fetch_exp(258, 9, "R1 tag 16 line 0");
        fetch_exp(259, 1, "R1 tag 16 hit");
        fetch_exp(2, 9, "R7 tag 0 evicted");
        @(negedge clk);
        chk("R8 final hits", 64'(hit_count), 64'd5);
        chk("R8 final misses", 64'(miss_count), 64'd6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule